// File: doc/BRIEF.md
# Sparsity Mode Classifier

This block sits beside the zero-run encoder on the write path of a feature map. It observes the stream of encoded pairs, each made of one data word and a short index that gives the length of the zero run that accompanied it. Once a fixed number of pairs has been seen, it decides whether the map should be kept in compressed storage. Short zero runs after non-zero words mean the map is busy, and long runs mean it is sparse. Sparsity is therefore judged by how many non-zero words carry an index below a programmable limit, rather than by counting zeros directly.

A one-cycle start pulse opens each new feature map. On that pulse the classifier returns to dense mode, which is uncompressed paired storage. It holds dense mode until the window of `WIN_LEN` pairs is complete. On the last pair of the window it latches its verdict, and that verdict stays fixed until the next start. If a map ends before the window is full, it stays dense. The intended settings are a window of 65536 pairs, an index limit of 8 and a count limit of 32768, held in a 16-bit saturating counter. Both limits are inputs, so software-free tuning is possible at integration.

Top module: `sparsity_classifier`

## Requirements
- R1: After reset, `compressed_o` and `decided_o` are both 0 (dense, undecided).
- R2: Every pair accepted with `pair_valid_i` high advances the window by one, counting from the start pulse. `decided_o` rises in the cycle after the `WIN_LEN`-th pair and never before it.
- R3: A pair adds to the hit count only when its data is non-zero and `pair_index_i` is strictly less than `idx_thresh_i`. An index equal to the limit does not count.
- R4: A pair whose data word is all zeros never adds to the hit count, whatever its index.
- R5: At the decision the map is dense (`compressed_o` = 0) if the hit count, including the final pair, is greater than `cnt_thresh_i`. Otherwise it is sparse (`compressed_o` = 1). A count equal to the limit gives sparse.
- R6: Once decided, `decided_o` and `compressed_o` hold their values, and further pairs have no effect until the next start pulse.
- R7: A start pulse returns both outputs to 0 in the next cycle and clears the window and hit count. A pair that is valid in the same cycle as the start is counted as the first pair of the new map.
- R8: While undecided, `compressed_o` is 0. A map that is restarted before `WIN_LEN` pairs have been seen ends in dense mode.
- R9: The hit counter saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse at the start of a feature map |
| pair_valid_i | input | 1 | An encoded pair is present this cycle |
| pair_data_i | input | DATA_W | Data word of the pair |
| pair_index_i | input | IDX_W | Zero-run length carried by the pair |
| idx_thresh_i | input | IDX_W | Index limit for a hit (intended 8) |
| cnt_thresh_i | input | CNT_W | Hit count above which the map is dense (intended 32768) |
| compressed_o | output | 1 | 1 selects compressed storage, 0 selects dense |
| decided_o | output | 1 | The window is complete and the verdict is latched |

## Verification
The critical overlap is a start pulse that falls in the same cycle as a valid pair. The new map must clear its state and still count that pair as both its first window entry and a hit. The bench provokes this by restarting a decided sparse map with a start that carries a hit pair, then filling the rest of the window with non-hits. The only way the map can come out dense is if the coinciding pair was counted, and the decision must appear exactly one pair early relative to a start without data. A behavioural reference model is compared with both outputs on every clock, so the same overlap is also judged cycle by cycle.

// File: rtl/sparsity_pkg.sv
package sparsity_pkg;
  localparam int unsigned DEF_WIN_LEN    = 65536;
  localparam int unsigned DEF_CNT_W      = 16;
  localparam int unsigned DEF_IDX_W      = 4;
  localparam int unsigned DEF_DATA_W     = 32;
  localparam int unsigned DEF_IDX_THRESH = 8;
  localparam int unsigned DEF_CNT_THRESH = 32768;

  // bits needed to hold the value len itself
  function automatic int unsigned win_bits(input int unsigned len);
    return $clog2(len + 1);
  endfunction
endpackage

// File: rtl/spc_window_ctr.sv
module spc_window_ctr #(
  parameter int unsigned WIN_LEN = 65536,
  parameter int unsigned WIN_W   = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam logic [WIN_W-1:0] LastIdx = WIN_W'(WIN_LEN - 1);

  logic [WIN_W-1:0] cnt_q, base;

  assign base   = clear_i ? '0 : cnt_q;
  assign last_o = step_i && (base == LastIdx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= base + 1'b1;
    else             cnt_q <= base;
  end
endmodule

// File: rtl/spc_hit_ctr.sv
module spc_hit_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] next_o
);
  logic [CNT_W-1:0] cnt_q, base;
  logic             full;

  assign base   = clear_i ? '0 : cnt_q;
  assign full   = &base;
  assign next_o = (inc_i && !full) ? base + 1'b1 : base;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= next_o;
  end
endmodule

// File: rtl/spc_mode_latch.sv
module spc_mode_latch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             decide_i,
  input  logic [CNT_W-1:0] hits_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             decided_o,
  output logic             compressed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decided_o    <= 1'b0;
      compressed_o <= 1'b0;
    end else if (decide_i) begin
      decided_o    <= 1'b1;
      compressed_o <= (hits_i <= thresh_i);
    end else if (clear_i) begin
      decided_o    <= 1'b0;
      compressed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sparsity_classifier.sv
module sparsity_classifier
  import sparsity_pkg::*;
#(
  parameter int unsigned WIN_LEN = DEF_WIN_LEN,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter int unsigned DATA_W  = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pair_valid_i,
  input  logic [DATA_W-1:0] pair_data_i,
  input  logic [IDX_W-1:0]  pair_index_i,
  input  logic [IDX_W-1:0]  idx_thresh_i,
  input  logic [CNT_W-1:0]  cnt_thresh_i,
  output logic              compressed_o,
  output logic              decided_o
);
  localparam int unsigned WIN_W = win_bits(WIN_LEN);

  logic             take, hit, last;
  logic [CNT_W-1:0] hit_cnt, hit_next;

  // a start reopens the window, so the same-cycle pair belongs to the new map
  assign take = pair_valid_i && (start_i || !decided_o);
  assign hit  = take && (|pair_data_i) && (pair_index_i < idx_thresh_i);

  spc_window_ctr #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i),
    .step_i (take),
    .last_o (last)
  );

  spc_hit_ctr #(.CNT_W(CNT_W)) u_hits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i),
    .inc_i  (hit),
    .cnt_o  (hit_cnt),
    .next_o (hit_next)
  );

  spc_mode_latch #(.CNT_W(CNT_W)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_i),
    .decide_i    (last),
    .hits_i      (hit_next),
    .thresh_i    (cnt_thresh_i),
    .decided_o   (decided_o),
    .compressed_o(compressed_o)
  );
endmodule

// File: rtl/sparsity_classifier_chk.sv
module sparsity_classifier_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             pair_valid_i,
  input logic             decided_o,
  input logic             compressed_o,
  input logic [CNT_W-1:0] hit_cnt
);
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !decided_o && !compressed_o); // R7

  AST_DENSE_UNDECIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decided_o |-> !compressed_o); // R8

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decided_o && !start_i |=> decided_o && $stable(compressed_o)); // R6

  AST_DECIDE_NEEDS_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decided_o && !pair_valid_i |=> !decided_o); // R2

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&hit_cnt) && !start_i |=> &hit_cnt); // R9
endmodule

bind sparsity_classifier sparsity_classifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pair_valid_i(pair_valid_i),
  .decided_o   (decided_o),
  .compressed_o(compressed_o),
  .hit_cnt     (hit_cnt)
);

// File: tb/sparsity_classifier_tb.sv
module sparsity_classifier_tb;
  localparam int WIN   = 20;
  localparam int CNTW  = 4;
  localparam int IDXW  = 4;
  localparam int DW    = 32;
  localparam int HMAX  = (1 << CNTW) - 1;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            start = 1'b0, valid = 1'b0;
  logic [DW-1:0]   data = '0;
  logic [IDXW-1:0] idx = '0, ith = 4'd8;
  logic [CNTW-1:0] cth = 4'd10;
  logic            comp, dec;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_cnt = 0, m_hits = 0, m_dec = 0, m_comp = 0;

  always #2.5 clk = ~clk;

  sparsity_classifier #(.WIN_LEN(WIN), .CNT_W(CNTW), .IDX_W(IDXW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pair_valid_i(valid),
    .pair_data_i(data), .pair_index_i(idx), .idx_thresh_i(ith),
    .cnt_thresh_i(cth), .compressed_o(comp), .decided_o(dec)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hits = 0; m_dec = 0; m_comp = 0;
    end else begin
      if (start) begin
        m_cnt = 0; m_hits = 0; m_dec = 0; m_comp = 0;
      end
      if (valid && m_dec == 0) begin
        m_cnt++;
        if (data != 0 && idx < ith && m_hits < HMAX) m_hits++;
        if (m_cnt == WIN) begin
          m_dec  = 1;
          m_comp = (m_hits <= cth) ? 1 : 0;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check({cur_req, " model decided"}, int'(dec), m_dec);
      check({cur_req, " model compressed"}, int'(comp), m_comp);
    end
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk); start = 1'b0; valid = 1'b0; data = '0; idx = '0;
  endtask

  task automatic pulse_start(input logic with_pair, input int d, input int ix);
    @(negedge clk); start = 1'b1; valid = with_pair; data = DW'(d); idx = IDXW'(ix);
  endtask

  task automatic pairs(input int n, input int d, input int ix);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); start = 1'b0; valid = 1'b1; data = DW'(d); idx = IDXW'(ix);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset decided", int'(dec), 0);
    check("R1 reset compressed", int'(comp), 0);
    rst_n = 1'b1;

    // R2/R3: busy map, decision exactly at the window end
    cur_req = "R2"; ith = 8; cth = 10;
    pulse_start(1'b0, 0, 0);
    pairs(WIN - 1, 5, 2); idle();
    check("R2 undecided before last pair", int'(dec), 0);
    pairs(1, 5, 2); idle();
    check("R2 decided after last pair", int'(dec), 1);
    check("R3 short runs give dense", int'(comp), 0);

    // R5: long runs give sparse
    cur_req = "R5";
    pulse_start(1'b0, 0, 0); pairs(WIN, 7, 12); idle();
    check("R5 long runs compressed", int'(comp), 1);

    // R5 boundary: hits == limit -> sparse, limit+1 -> dense
    pulse_start(1'b0, 0, 0); pairs(10, 3, 1); pairs(WIN - 10, 3, 9); idle();
    check("R5 hits equal limit", int'(comp), 1);
    pulse_start(1'b0, 0, 0); pairs(11, 3, 1); pairs(WIN - 11, 3, 9); idle();
    check("R5 hits above limit", int'(comp), 0);

    // R3: index equal to limit is not a hit, one below is
    cur_req = "R3"; cth = 0;
    pulse_start(1'b0, 0, 0); pairs(WIN, 9, 8); idle();
    check("R3 index equal limit not counted", int'(comp), 1);
    pulse_start(1'b0, 0, 0); pairs(1, 9, 7); pairs(WIN - 1, 9, 8); idle();
    check("R3 index below limit counted", int'(comp), 0);

    // R4: zero data never counts
    cur_req = "R4";
    pulse_start(1'b0, 0, 0); pairs(WIN, 0, 0); idle();
    check("R4 zero data ignored", int'(comp), 1);

    // R6: verdict held against later hit pairs
    cur_req = "R6";
    pairs(WIN + 5, 1, 0); idle(); idle();
    check("R6 decided held", int'(dec), 1);
    check("R6 compressed held", int'(comp), 1);

    // R8: short map stays dense
    cur_req = "R8";
    pulse_start(1'b0, 0, 0); pairs(10, 1, 0); idle();
    check("R8 short map undecided", int'(dec), 0);
    check("R8 short map dense", int'(comp), 0);
    pulse_start(1'b0, 0, 0); idle();
    check("R8 restart stays dense", int'(comp), 0);

    // R7: start coinciding with a hit pair
    cur_req = "R7";
    pulse_start(1'b0, 0, 0); pairs(WIN, 4, 12); idle();
    check("R7 prior map sparse", int'(comp), 1);
    pulse_start(1'b1, 6, 0); idle();
    check("R7 start clears decided", int'(dec), 0);
    check("R7 start clears compressed", int'(comp), 0);
    pairs(WIN - 2, 6, 12); idle();
    check("R7 undecided one pair short", int'(dec), 0);
    pairs(1, 6, 12); idle();
    check("R7 same-cycle pair opens window", int'(dec), 1);
    check("R7 same-cycle pair counted as hit", int'(comp), 0);

    // R9: saturation (wrap would leave 4 hits, below the limit)
    cur_req = "R9"; cth = 10;
    pulse_start(1'b0, 0, 0); pairs(WIN, 2, 0); idle();
    check("R9 saturated count dense", int'(comp), 0);

    idle(); idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule